// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block executes a single memory-to-memory DMA transfer for one channel. A transfer is set up by presenting a 32-bit control word, an inclusive source end pointer and an inclusive destination end pointer, then pulsing `start_i`. The control word carries the data size, the source and destination address steps, a re-arbitration group size, the item count (stored as count minus one) and the transfer mode. Because the pointers name the last byte touched, the engine computes each item address by stepping backwards from the end pointer by the number of items still outstanding. The last item therefore lands exactly on the pointer.

Each item is moved as a read on the memory port followed by a write in the next cycle. After every group of 2^n items the engine spends one cycle yielding the bus. In basic mode items move only while a request is present. In auto mode the first request starts the transfer, and it then runs to the end without further requests. When the count is exhausted, the engine presents the control word with its mode and count fields cleared for write-back, pulses `done_o`, and returns to idle.

The controller is built around states IDLE, WAIT, READ, WRITE, YIELD and FINISH, with these transitions:
- IDLE to WAIT on an accepted start.
- WAIT to READ when a trigger is present.
- READ to WRITE always.
- WRITE to FINISH on the last item.
- WRITE to YIELD when a group fills.
- WRITE to WAIT when basic mode loses its trigger.
- WRITE to READ otherwise.
- YIELD to READ in auto mode, or to WAIT in basic mode.
- FINISH to IDLE always.

Top module: `dma_xfer_engine`

## Requirements
- R1: A start with a valid basic (mode 1) or auto (mode 2) control word is accepted. On the following cycle `mode_o` shows that mode and `remaining_o` shows the item count, which is the count field in bits 13:4 plus one (1 to 1024).
- R2: Item i (from 0) of an N-item transfer uses address end − ((N−1−i) << inc) on each side. The step code sits in bits 27:26 for the source and bits 31:30 for the destination, with 0/1/2 meaning 1/2/4 bytes. Step code 3 keeps the address fixed at the end pointer.
- R3: `size_o` carries the data-size code from bits 25:24 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) during every read and write.
- R4: A start whose control word has any of the following raises `cfg_err_o` for one cycle, starts nothing and leaves `remaining_o` at zero: size code 3, an incrementing step code smaller than the size code, an arbitration code in bits 17:14 above 10, or a mode other than 0, 1 or 2. A start with mode 0 is ignored without error.
- R5: In basic mode a read is issued only in a cycle after a trigger was present. If the trigger is withdrawn, the engine pauses after the current item and holds its progress.
- R6: In auto mode one trigger starts the transfer, and every item is then moved even if the request is withdrawn.
- R7: With the next-use-burst flag (bit 3) set, `req_i` alone is no trigger and only `burst_req_i` starts or continues items. With the flag clear, either input is a trigger.
- R8: After every 2^arb items, where arb is the code in bits 17:14, `yield_o` pulses for one cycle unless the transfer has just ended. An N-item transfer yields (N−1) >> arb times.
- R9: `remaining_o` decreases by one on each write. During a pause it reports the number of items still outstanding.
- R10: At completion `done_o` pulses for exactly one cycle, together with `wb_valid_o`. In that cycle `remaining_o` and `mode_o` are zero, and `wb_ctrl_o` equals the control word with bits 13:4 and 2:0 cleared.
- R11: Every read is followed in the next cycle by one write, and never in the same cycle. The write data is the value returned on `rd_data_i` for that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in idle |
| ctrl_i | input | 32 | Control word |
| src_end_i | input | ADDR_W | Inclusive source end pointer |
| dst_end_i | input | ADDR_W | Inclusive destination end pointer |
| req_i | input | 1 | Single request |
| burst_req_i | input | 1 | Burst request |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, valid the cycle after `rd_en_o` |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| size_o | output | 2 | Data-size code of the access |
| yield_o | output | 1 | One-cycle re-arbitration point |
| done_o | output | 1 | One-cycle completion pulse |
| mode_o | output | 3 | Mode of the running transfer, 0 when idle |
| remaining_o | output | 11 | Items still to move |
| cfg_err_o | output | 1 | Rejected-start pulse |
| wb_valid_o | output | 1 | Write-back word valid |
| wb_ctrl_o | output | 32 | Control word to write back |

## Verification
The properties assume a memory that returns read data in the cycle after the strobe and never stalls. They also assume that the address step is no finer than the data size, since the engine rejects any word that breaks this before it reaches a busy state. The stimulus only builds words with step codes at or above the size code for its address sweeps. Illegal combinations are sent only to the rejection checks, and requests are changed between clock edges so that a basic-mode pause lands on a known item.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int CTRL_W     = 32;
    localparam int CNT_W      = 10;
    localparam int REM_W      = CNT_W + 1;
    localparam int ARB_MAX    = 10;

    localparam int DINC_LO    = 30;
    localparam int SINC_LO    = 26;
    localparam int SIZE_LO    = 24;
    localparam int ARB_LO     = 14;
    localparam int CNT_LO     = 4;
    localparam int NXB_BIT    = 3;
    localparam int MODE_LO    = 0;

    localparam logic [2:0] MODE_STOP  = 3'd0;
    localparam logic [2:0] MODE_BASIC = 3'd1;
    localparam logic [2:0] MODE_AUTO  = 3'd2;
    localparam logic [1:0] STEP_FIXED = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_YIELD,
        ST_FINISH
    } eng_state_e;

    typedef struct packed {
        logic [1:0]       dst_step;
        logic [1:0]       src_step;
        logic [1:0]       size;
        logic [3:0]       arb;
        logic [CNT_W-1:0] cnt_m1;
        logic             next_burst;
        logic [2:0]       mode;
    } xfer_fields_t;

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
    import dma_eng_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_word,
    output xfer_fields_t      fields,
    output logic              cfg_bad,
    output logic              runnable
);

    logic unused_mirror;
    logic src_bad, dst_bad, mode_bad;

    assign unused_mirror = ^{ctrl_word[29:28], ctrl_word[23:18]};

    assign fields.dst_step   = ctrl_word[DINC_LO +: 2];
    assign fields.src_step   = ctrl_word[SINC_LO +: 2];
    assign fields.size       = ctrl_word[SIZE_LO +: 2];
    assign fields.arb        = ctrl_word[ARB_LO +: 4];
    assign fields.cnt_m1     = ctrl_word[CNT_LO +: CNT_W];
    assign fields.next_burst = ctrl_word[NXB_BIT];
    assign fields.mode       = ctrl_word[MODE_LO +: 3];

    assign src_bad  = (fields.src_step != STEP_FIXED) && (fields.src_step < fields.size);
    assign dst_bad  = (fields.dst_step != STEP_FIXED) && (fields.dst_step < fields.size);
    assign mode_bad = (fields.mode != MODE_STOP) && (fields.mode != MODE_BASIC)
                   && (fields.mode != MODE_AUTO);
    assign runnable = (fields.mode == MODE_BASIC) || (fields.mode == MODE_AUTO);
    assign cfg_bad  = (fields.size == 2'd3) || src_bad || dst_bad || mode_bad
                   || (int'(fields.arb) > ARB_MAX);

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] end_ptr,
    input  logic [REM_W-1:0]  items_left,
    input  logic [1:0]        step,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] back_items;
    logic [ADDR_W-1:0] back_bytes;

    always_comb begin
        back_items = ADDR_W'(items_left) - ADDR_W'(1);
        back_bytes = back_items << step;
        if (step == STEP_FIXED) begin
            addr = end_ptr;
        end else begin
            addr = end_ptr - back_bytes;
        end
    end

endmodule

// File: rtl/dma_item_counter.sv
module dma_item_counter
    import dma_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REM_W-1:0] load_val,
    input  logic             dec,
    input  logic             grp_clr,
    input  logic [3:0]       arb,
    output logic [REM_W-1:0] items_left,
    output logic             is_last,
    output logic             grp_full
);

    logic [REM_W-1:0] grp_cnt;
    logic [REM_W-1:0] grp_size;

    assign grp_size = REM_W'(1) << arb;
    assign grp_full = (grp_cnt + REM_W'(1)) == grp_size;
    assign is_last  = items_left == REM_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            items_left <= '0;
            grp_cnt    <= '0;
        end else begin
            if (load) begin
                items_left <= load_val;
            end else if (dec) begin
                items_left <= items_left - REM_W'(1);
            end
            if (load || grp_clr) begin
                grp_cnt <= '0;
            end else if (dec) begin
                grp_cnt <= grp_cnt + REM_W'(1);
            end
        end
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [ADDR_W-1:0] src_end_i,
    input  logic [ADDR_W-1:0] dst_end_i,
    input  logic              req_i,
    input  logic              burst_req_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [1:0]        size_o,
    output logic              yield_o,
    output logic              done_o,
    output logic [2:0]        mode_o,
    output logic [REM_W-1:0]  remaining_o,
    output logic              cfg_err_o,
    output logic              wb_valid_o,
    output logic [CTRL_W-1:0] wb_ctrl_o
);

    eng_state_e        state_q, state_d;
    logic [ADDR_W-1:0] src_end_q, dst_end_q;
    logic [CTRL_W-1:0] ctrl_q, dec_word;
    xfer_fields_t      fld;
    logic              cfg_bad, runnable, accept, trigger, is_basic;
    logic              is_last, grp_full, cfg_err_q;
    logic [REM_W-1:0]  items_left;

    // In idle the incoming word is decoded for acceptance; afterwards the held copy.
    assign dec_word = (state_q == ST_IDLE) ? ctrl_i : ctrl_q;

    dma_ctrl_decode u_decode (
        .ctrl_word (dec_word),
        .fields    (fld),
        .cfg_bad   (cfg_bad),
        .runnable  (runnable)
    );

    assign accept   = (state_q == ST_IDLE) && start_i && runnable && !cfg_bad;
    assign trigger  = burst_req_i || (req_i && !fld.next_burst);
    assign is_basic = fld.mode == MODE_BASIC;

    dma_item_counter u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_val   (REM_W'(fld.cnt_m1) + REM_W'(1)),
        .dec        (state_q == ST_WRITE),
        .grp_clr    ((state_q == ST_WAIT) || (state_q == ST_YIELD)),
        .arb        (fld.arb),
        .items_left (items_left),
        .is_last    (is_last),
        .grp_full   (grp_full)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W)) u_src_addr (
        .end_ptr    (src_end_q),
        .items_left (items_left),
        .step       (fld.src_step),
        .addr       (rd_addr_o)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W)) u_dst_addr (
        .end_ptr    (dst_end_q),
        .items_left (items_left),
        .step       (fld.dst_step),
        .addr       (wr_addr_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transfer descriptor capture and rejection flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_end_q <= '0;
            dst_end_q <= '0;
            ctrl_q    <= '0;
            cfg_err_q <= 1'b0;
        end else begin
            cfg_err_q <= (state_q == ST_IDLE) && start_i && cfg_bad;
            if (accept) begin
                src_end_q <= src_end_i;
                dst_end_q <= dst_end_i;
                ctrl_q    <= ctrl_i;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_WAIT;
            ST_WAIT:   if (trigger) state_d = ST_READ;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE: begin
                if (is_last) begin
                    state_d = ST_FINISH;
                end else if (grp_full) begin
                    state_d = ST_YIELD;
                end else if (is_basic && !trigger) begin
                    state_d = ST_WAIT;
                end else begin
                    state_d = ST_READ;
                end
            end
            ST_YIELD:  state_d = is_basic ? ST_WAIT : ST_READ;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_en_o    = 1'b0;
        wr_en_o    = 1'b0;
        yield_o    = 1'b0;
        done_o     = 1'b0;
        wb_valid_o = 1'b0;
        mode_o     = fld.mode;
        unique case (state_q)
            ST_IDLE:   mode_o = MODE_STOP;
            ST_WAIT:   ;
            ST_READ:   rd_en_o = 1'b1;
            ST_WRITE:  wr_en_o = 1'b1;
            ST_YIELD:  yield_o = 1'b1;
            ST_FINISH: begin
                done_o     = 1'b1;
                wb_valid_o = 1'b1;
                mode_o     = MODE_STOP;
            end
            default:   mode_o = MODE_STOP;
        endcase
        wb_ctrl_o                    = ctrl_q;
        wb_ctrl_o[CNT_LO +: CNT_W]   = '0;
        wb_ctrl_o[MODE_LO +: 3]      = MODE_STOP;
    end

    assign wr_data_o   = rd_data_i;
    assign size_o      = fld.size;
    assign remaining_o = items_left;
    assign cfg_err_o   = cfg_err_q;

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk
    import dma_eng_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic             burst_req_i,
    input logic             rd_en_o,
    input logic             wr_en_o,
    input logic             yield_o,
    input logic             done_o,
    input logic [2:0]       mode_o,
    input logic [REM_W-1:0] remaining_o,
    input logic             cfg_err_o,
    input logic [CTRL_W-1:0] wb_ctrl_o
);

    p_read_then_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> wr_en_o);

    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_o && wr_en_o));

    p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (remaining_o == $past(remaining_o) - REM_W'(1)));

    p_done_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (remaining_o == '0) && (mode_o == MODE_STOP) && (wb_ctrl_o[2:0] == 3'd0));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_reject_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (mode_o == MODE_STOP) && !rd_en_o && (remaining_o == '0));

    p_basic_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && mode_o == MODE_BASIC) |-> $past(req_i || burst_req_i));

    p_yield_midway_r8: assert property (@(posedge clk) disable iff (!rst_n)
        yield_o |-> (remaining_o != '0) && !done_o);

endmodule

bind dma_xfer_engine dma_xfer_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .burst_req_i (burst_req_i),
    .rd_en_o     (rd_en_o),
    .wr_en_o     (wr_en_o),
    .yield_o     (yield_o),
    .done_o      (done_o),
    .mode_o      (mode_o),
    .remaining_o (remaining_o),
    .cfg_err_o   (cfg_err_o),
    .wb_ctrl_o   (wb_ctrl_o)
);

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] ctrl_i = '0;
    logic [31:0] src_end_i = '0;
    logic [31:0] dst_end_i = '0;
    logic        req_i = 1'b0;
    logic        burst_req_i = 1'b0;
    logic        rd_en_o, wr_en_o, yield_o, done_o, cfg_err_o, wb_valid_o;
    logic [31:0] rd_addr_o, wr_addr_o, wr_data_o, wb_ctrl_o;
    logic [31:0] rd_data = '0;
    logic [1:0]  size_o;
    logic [2:0]  mode_o;
    logic [10:0] remaining_o;

    int checks = 0;
    int errors = 0;
    int idx = 0, rd_cnt = 0, yld_cnt = 0;
    int e_n = 1, e_sinc = 0, e_dinc = 0, e_size = 0;
    logic [31:0] e_src_end = '0, e_dst_end = '0, e_ctrl = '0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_xfer_engine u_dma_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
        .src_end_i(src_end_i), .dst_end_i(dst_end_i), .req_i(req_i),
        .burst_req_i(burst_req_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .size_o(size_o), .yield_o(yield_o),
        .done_o(done_o), .mode_o(mode_o), .remaining_o(remaining_o),
        .cfg_err_o(cfg_err_o), .wb_valid_o(wb_valid_o), .wb_ctrl_o(wb_ctrl_o)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
    endfunction

    function automatic logic [31:0] end_of(input logic [31:0] s, input int n, input int inc);
        return (inc == 3) ? s : s + (32'(n) << inc) - 32'd1;
    endfunction

    function automatic logic [31:0] addr_of(input logic [31:0] e, input int n, input int i, input int inc);
        return (inc == 3) ? e : e - (32'(n - 1 - i) << inc);
    endfunction

    function automatic logic [31:0] mk_ctrl(input int dinc, input int sinc, input int size,
                                            input int arb, input int n, input int nxb, input int mode);
        return {dinc[1:0], size[1:0], sinc[1:0], size[1:0], 6'd0, arb[3:0],
                10'(n - 1), nxb[0], mode[2:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Memory model and per-item monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en_o) begin
                rd_cnt++;
                chk(rd_addr_o == addr_of(e_src_end, e_n, idx, e_sinc), "R2 source address",
                    rd_addr_o, addr_of(e_src_end, e_n, idx, e_sinc));
                chk(size_o == 2'(e_size), "R3 read size", size_o, e_size);
                rd_data <= pat(rd_addr_o);
            end
            if (wr_en_o) begin
                chk(wr_addr_o == addr_of(e_dst_end, e_n, idx, e_dinc), "R2 destination address",
                    wr_addr_o, addr_of(e_dst_end, e_n, idx, e_dinc));
                chk(wr_data_o == pat(addr_of(e_src_end, e_n, idx, e_sinc)), "R11 write data",
                    wr_data_o, pat(addr_of(e_src_end, e_n, idx, e_sinc)));
                chk(size_o == 2'(e_size), "R3 write size", size_o, e_size);
                idx++;
            end
            if (yield_o) yld_cnt++;
        end
    end

    task automatic launch(input int size, input int sinc, input int dinc, input int arb,
                          input int n, input int nxb, input int mode,
                          input logic [31:0] s0, input logic [31:0] d0);
        e_ctrl = mk_ctrl(dinc, sinc, size, arb, n, nxb, mode);
        e_size = size; e_sinc = sinc; e_dinc = dinc; e_n = n;
        e_src_end = end_of(s0, n, sinc);
        e_dst_end = end_of(d0, n, dinc);
        idx = 0; rd_cnt = 0; yld_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; ctrl_i = e_ctrl; src_end_i = e_src_end; dst_end_i = e_dst_end;
        @(negedge clk);
        start_i = 1'b0;
        chk(mode_o == 3'(mode), "R1 mode shown", mode_o, mode);
        chk(remaining_o == 11'(n), "R1 count loaded", remaining_o, n);
    endtask

    task automatic finish_xfer(input int exp_yields);
        int k;
        for (k = 0; k < 6000; k++) begin
            @(negedge clk);
            if (done_o) break;
        end
        chk(done_o == 1'b1, "R10 done seen", done_o, 1);
        chk(wb_valid_o == 1'b1, "R10 write-back valid", wb_valid_o, 1);
        chk(remaining_o == 11'd0, "R10 remaining zero", remaining_o, 0);
        chk(mode_o == 3'd0, "R10 mode stop", mode_o, 0);
        chk(wb_ctrl_o == (e_ctrl & ~32'h0000_3FF7), "R10 write-back word", wb_ctrl_o,
            e_ctrl & ~32'h0000_3FF7);
        chk(idx == e_n, "R9 item total", idx, e_n);
        chk(yld_cnt == exp_yields, "R8 yield count", yld_cnt, exp_yields);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single cycle", done_o, 0);
    endtask

    task automatic reject(input logic [31:0] c, input bit exp_err, input string tag);
        rd_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; ctrl_i = c;
        @(negedge clk);
        start_i = 1'b0;
        chk(cfg_err_o == exp_err, tag, cfg_err_o, exp_err);
        chk(mode_o == 3'd0, "R4 no start mode", mode_o, 0);
        chk(remaining_o == 11'd0, "R4 no start count", remaining_o, 0);
        repeat (3) @(negedge clk);
        chk(rd_cnt == 0, "R4 no reads", rd_cnt, 0);
        chk(cfg_err_o == 1'b0, "R4 error is a pulse", cfg_err_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(remaining_o == 11'd0, "R9 reset count", remaining_o, 0);
        chk(mode_o == 3'd0, "R1 reset mode", mode_o, 0);
        chk(!rd_en_o && !wr_en_o && !done_o && !yield_o && !cfg_err_o,
            "R11 reset strobes idle", {rd_en_o, wr_en_o, done_o, yield_o, cfg_err_o}, 0);

        // Sweep of sizes, legal step codes, counts, group sizes and both modes
        req_i = 1'b1;
        for (int sz = 0; sz < 3; sz++)
            for (int si = sz; si < 4; si++)
                for (int di = sz; di < 4; di++)
                    for (int nn = 0; nn < 3; nn++)
                        for (int ab = 0; ab < 2; ab++) begin
                            int n;
                            int arb;
                            n = (nn == 0) ? 1 : (nn == 1) ? 3 : 8;
                            arb = ab * 2;
                            launch(sz, si, di, arb, n, 0, 1 + ((si + di + nn) % 2),
                                   32'h0001_0000 + 32'(sz * 64 + si * 16), 32'h0008_0400 + 32'(di * 32));
                            finish_xfer((n - 1) >> arb);
                        end

        // Maximum count, whole transfer in one group, then small groups
        launch(2, 2, 2, 10, 1024, 0, 2, 32'h0010_0000, 32'h0020_0000);
        finish_xfer(1023 >> 10);
        launch(0, 0, 3, 3, 1024, 0, 1, 32'h0030_0000, 32'h4000_0010);
        finish_xfer(1023 >> 3);

        // R8 group sizes in both modes
        launch(1, 1, 1, 1, 9, 0, 2, 32'h0000_2000, 32'h0000_3000);
        finish_xfer(4);
        launch(1, 2, 1, 2, 9, 0, 1, 32'h0000_2100, 32'h0000_3100);
        finish_xfer(2);

        // R5 / R9: basic mode waits for a request and pauses when it drops
        req_i = 1'b0;
        launch(0, 0, 0, 10, 4, 0, 1, 32'h0000_5000, 32'h0000_6000);
        repeat (5) @(negedge clk);
        chk(rd_cnt == 0, "R5 no read without request", rd_cnt, 0);
        req_i = 1'b1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (rd_en_o && idx == 1) break;
        end
        req_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(rd_cnt == 2, "R5 pause after current item", rd_cnt, 2);
        chk(remaining_o == 11'd2, "R9 outstanding during pause", remaining_o, 2);
        req_i = 1'b1;
        finish_xfer(0);

        // R6: auto mode runs to completion after the request is withdrawn
        req_i = 1'b0;
        e_ctrl = mk_ctrl(1, 1, 1, 1, 6, 0, 2);
        e_size = 1; e_sinc = 1; e_dinc = 1; e_n = 6;
        e_src_end = end_of(32'h0000_7000, 6, 1);
        e_dst_end = end_of(32'h0000_8000, 6, 1);
        idx = 0; rd_cnt = 0; yld_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; req_i = 1'b1; ctrl_i = e_ctrl; src_end_i = e_src_end; dst_end_i = e_dst_end;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        req_i = 1'b0;
        finish_xfer(2);
        chk(idx == 6, "R6 auto completes without request", idx, 6);

        // R7: next-use-burst ignores single requests
        req_i = 1'b1; burst_req_i = 1'b0;
        launch(2, 3, 2, 10, 3, 1, 1, 32'h0000_9000, 32'h0000_A000);
        repeat (5) @(negedge clk);
        chk(rd_cnt == 0, "R7 single request ignored", rd_cnt, 0);
        burst_req_i = 1'b1;
        finish_xfer(0);
        burst_req_i = 1'b0;
        // R7: burst request alone also triggers when the flag is clear
        req_i = 1'b0; burst_req_i = 1'b1;
        launch(0, 1, 0, 0, 2, 0, 1, 32'h0000_B000, 32'h0000_C000);
        finish_xfer(1);
        burst_req_i = 1'b0; req_i = 1'b1;

        // R4: rejected configurations, and an ignored stop word
        reject(mk_ctrl(0, 0, 1, 0, 4, 0, 1), 1'b1, "R4 source step below size");
        reject(mk_ctrl(1, 2, 2, 0, 4, 0, 2), 1'b1, "R4 destination step below size");
        reject(mk_ctrl(3, 3, 3, 0, 4, 0, 1), 1'b1, "R4 size code 3");
        reject(mk_ctrl(0, 0, 0, 11, 4, 0, 1), 1'b1, "R4 arbitration above 10");
        reject(mk_ctrl(0, 0, 0, 0, 4, 0, 3), 1'b1, "R4 unsupported mode 3");
        reject(mk_ctrl(0, 0, 0, 0, 4, 0, 4), 1'b1, "R4 unsupported mode 4");
        reject(mk_ctrl(0, 0, 0, 0, 4, 0, 0), 1'b0, "R4 stop word ignored");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule